// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block produces the address of the next microinstruction fetched from a 4096-word control store. Each microinstruction supplies a successor address in its own next-address field, so an unconditional jump adds no cycles. A two-bit sequence code chooses how that field is used: as a direct jump target, ignored in favour of a plain increment, as the taken target of a conditional branch, or as the page for a 256-way dispatch on an external byte (for example the opcode at the head of an instruction buffer).

A reuse flag marks instructions whose next-address field carries other data. In those instructions the successor is always the current address plus one, whatever the sequence code says. A stall input freezes the address register so the same microinstruction is presented again.

Top module: `useq_next_addr`

## Requirements
- R1: After reset the address output is 0.
- R2: With sequence code 2'b00 and the reuse flag low, the next address equals the 12-bit next-address field.
- R3: With sequence code 2'b01, the next address is the current address plus one, wrapping from 4095 to 0.
- R4: With sequence code 2'b10, the next address is the field when the condition input selected by the 2-bit condition index (bit position in the condition vector) is 1, and the current address plus one otherwise.
- R5: With sequence code 2'b11, the next address is {field[11:8], dispatch byte}.
- R6: When the reuse flag is high, the next address is the current address plus one for every sequence code.
- R7: While stall is high, the address output keeps its value.
- R8: The address changes only on a rising clock edge; each instruction produces its successor exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hold the current address |
| nxt_field | input | 12 | Next-address field of the current microinstruction |
| seq_code | input | 2 | Sequence code: 00 jump, 01 increment, 10 conditional, 11 dispatch |
| reuse | input | 1 | Next-address field carries other data; force increment |
| cond_sel | input | 2 | Index of the condition bit tested in conditional mode |
| cond_in | input | 4 | Condition inputs |
| disp_byte | input | 8 | Byte used by the 256-way dispatch |
| uaddr | output | 12 | Control-store address |

## Verification
A wrong address register shows at the port in the very next cycle, since uaddr is the register itself and every mode feeds the following value from it. A wrong mode decode or a corrupted increment would send execution to an unexpected control-store word one cycle after the instruction that chose it, so every check compares uaddr one edge after the fields are driven. A stuck stall path shows as an address that either moves during a stall or fails to move after it ends.

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int NC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stall,
  input  logic [AW-1:0]          nxt_field,
  input  logic [1:0]             seq_code,
  input  logic                   reuse,
  input  logic [$clog2(NC)-1:0]  cond_sel,
  input  logic [NC-1:0]          cond_in,
  input  logic [DW-1:0]          disp_byte,
  output logic [AW-1:0]          uaddr
);
  localparam int PW = AW - DW;

  logic [AW-1:0] inc_addr, nxt_addr;
  logic          cond_hit;

  assign inc_addr = uaddr + AW'(1);
  assign cond_hit = cond_in[cond_sel];

  always_comb begin
    if (reuse) nxt_addr = inc_addr;
    else begin
      case (seq_code)
        2'b00:   nxt_addr = nxt_field;
        2'b01:   nxt_addr = inc_addr;
        2'b10:   nxt_addr = cond_hit ? nxt_field : inc_addr;
        default: nxt_addr = {nxt_field[AW-1 -: PW], disp_byte};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      uaddr <= '0;
    else if (!stall) uaddr <= nxt_addr;
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> uaddr == '0);
  p_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !reuse && seq_code == 2'b00) |=> uaddr == $past(nxt_field));
  p_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && seq_code == 2'b01) |=> uaddr == $past(uaddr) + AW'(1));
  p_dispatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !reuse && seq_code == 2'b11) |=>
      uaddr == {$past(nxt_field[AW-1 -: PW]), $past(disp_byte)});
  p_reuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && reuse) |=> uaddr == $past(uaddr) + AW'(1));
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(uaddr));
endmodule

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
  logic        clk = 0, rst_n = 0, stall = 0, reuse = 0;
  logic [11:0] nxt_field = 0;
  logic [1:0]  seq_code = 0, cond_sel = 0;
  logic [3:0]  cond_in = 0;
  logic [7:0]  disp_byte = 0;
  logic [11:0] uaddr;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  useq_next_addr u_dut (.clk, .rst_n, .stall, .nxt_field, .seq_code, .reuse,
                        .cond_sel, .cond_in, .disp_byte, .uaddr);

  task automatic chk(string req, logic [11:0] exp);
    n_run++;
    if (uaddr !== exp) begin
      n_fail++;
      $display("FAIL %s: uaddr=%0d expected=%0d", req, uaddr, exp);
    end
  endtask

  task automatic step(logic [1:0] c, logic [11:0] f, logic r = 0, logic s = 0);
    seq_code = c; nxt_field = f; reuse = r; stall = s;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 0; step(2'b00, 12'h5A5); step(2'b00, 12'h5A5);
    chk("R1", 0);
    rst_n = 1;
  endtask

  task automatic t_jump;
    step(2'b00, 12'h123); chk("R2", 12'h123);
    step(2'b00, 12'hFFF); chk("R2", 12'hFFF);
  endtask

  task automatic t_incr;
    step(2'b01, 12'h000); chk("R3 wrap", 12'h000);
    step(2'b01, 12'h777); chk("R3", 12'h001);
  endtask

  task automatic t_cond;
    step(2'b00, 12'h200);
    cond_in = 4'b0100; cond_sel = 2; step(2'b10, 12'h0AB); chk("R4 taken", 12'h0AB);
    cond_sel = 1; step(2'b10, 12'h300); chk("R4 not taken", 12'h0AC);
    cond_in = 4'b1000; cond_sel = 3; step(2'b10, 12'h3C3); chk("R4 bit3", 12'h3C3);
  endtask

  task automatic t_disp;
    disp_byte = 8'h5E; step(2'b11, 12'hA12); chk("R5", 12'hA5E);
    disp_byte = 8'hFF; step(2'b11, 12'h3FF); chk("R5", 12'h3FF);
  endtask

  task automatic t_reuse;
    step(2'b00, 12'h040);
    step(2'b00, 12'h999, 1); chk("R6 jump", 12'h041);
    disp_byte = 8'h11; step(2'b11, 12'h999, 1); chk("R6 dispatch", 12'h042);
    cond_in = 4'hF; cond_sel = 0; step(2'b10, 12'h999, 1); chk("R6 cond", 12'h043);
  endtask

  task automatic t_stall;
    step(2'b00, 12'h600, 0, 1); chk("R7", 12'h043);
    step(2'b01, 12'h600, 0, 1); chk("R7", 12'h043);
    step(2'b00, 12'h600); chk("R8 resume", 12'h600);
  endtask

  task automatic t_timing;
    seq_code = 2'b00; nxt_field = 12'h0F0; reuse = 0; stall = 0;
    @(negedge clk); chk("R8 no early change", 12'h600);
    @(posedge clk); #1; chk("R8", 12'h0F0);
  endtask

  initial begin
    #1;
    t_reset; t_jump; t_incr; t_cond; t_disp; t_reuse; t_stall; t_timing;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule